// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast clock by an integer ratio M = 4·P + S. P is a 7-bit program count and S is a 2-bit swallow count. Inside, a prescaler divides the input clock by 5 or by 4 and produces one enable per prescaler period. Two down-counters advance on that enable.

While the swallow count is non-zero, the prescaler divides by 5. Once the swallow count reaches zero, it divides by 4. The program counter decides when an output cycle ends.

The end of an output cycle is recognised one count early, when the program counter holds 1 rather than 0. The reload of both counters then lands exactly on the boundary of the last prescaler period. Detection, preset and the return to divide-by-5 therefore never have to fit between two input edges. The block is fully synchronous to the input clock.

New preset values are sampled only at a reload. Software or a loop controller can change them at any time without disturbing the cycle in progress.

Top module: `pswallow_divider`

## Requirements
- R1: With presets P and S where 2 ≤ P ≤ 127 and 0 ≤ S ≤ min(P,3), consecutive rising edges of `div_out` are exactly 4·P + S input clock cycles apart. For example, P=112 and S=2 gives 450, and P=127 and S=3 gives 511.
- R2: Within each output cycle, `mode_ctl` (1 = divide by 5, 0 = divide by 4) is high for the first 5·S input cycles and for no others.
- R3: Once `mode_ctl` has dropped within an output cycle, it stays low until the next reload.
- R4: `reload` is high for exactly one input cycle per output cycle. It is high in the same cycle in which `div_out` rises.
- R5: `div_out` stays high for exactly one prescaler period after each reload: 5 input cycles when S > 0 and 4 when S = 0.
- R6: A change of `p_preset` or `s_preset` has no effect on the output cycle in progress. It sets the length of the cycle that starts at the next reload.
- R7: While `rst_n` is low, `div_out` and `reload` are 0 at every clock edge, and `mode_ctl` equals 1 exactly when `s_preset` is non-zero.
- R8: Every ratio from 240 to 400 is reachable with no gaps, using P = M div 4 and S = M mod 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| p_preset | input | 7 | Program count P, sampled at reset and at each reload |
| s_preset | input | 2 | Swallow count S, sampled at reset and at each reload |
| div_out | output | 1 | Divided clock, high for one prescaler period per output cycle |
| mode_ctl | output | 1 | Prescaler modulus: 1 = divide by 5, 0 = divide by 4 |
| reload | output | 1 | One-cycle pulse marking the counter reload |

## Verification
A corrupted program or swallow count shows up as a wrong spacing between `div_out` rising edges. It is visible at the very next edge, at most 511 input cycles later. A swallow counter that fails to stop at zero, or that stops early, appears within the same output cycle as a wrong number of divide-by-5 cycles on `mode_ctl`. A prescaler phase error stretches or shortens the `div_out` high time in the cycle where it occurs. A missed or doubled reload breaks the one-pulse-per-cycle pairing of `reload` and `div_out`.

// File: rtl/psdiv_pkg.sv
// Shared constants for the pulse-swallow divider.
// Assumes the prescaler's low modulus is 4 and its high modulus is 5.
package psdiv_pkg;
    localparam int PRE_N = 4;   // low prescaler modulus
    localparam int P_BITS = 7;  // program counter width
    localparam int S_BITS = 2;  // swallow counter width
endpackage

// File: rtl/dm_prescaler.sv
// Dual-modulus prescaler modelled as a phase counter.
// It divides clk by N+1 when div_hi is 1 and by N when div_hi is 0, and
// it raises tick during the last input cycle of each prescaler period.
// Assumes div_hi changes only on the edge that closes a period.
module dm_prescaler #(
    parameter int N = psdiv_pkg::PRE_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_hi,
    output logic tick
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST_HI = CW'(N);
    localparam logic [CW-1:0] LAST_LO = CW'(N - 1);

    logic [CW-1:0] phase;

    // Period end: the phase reaches the last slot of the selected modulus.
    assign tick = (phase == (div_hi ? LAST_HI : LAST_LO));

    // Advance the phase; wrap it at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end
endmodule

// File: rtl/prog_counter.sv
// Program counter P with early terminal detection.
// It counts down once per prescaler period. The terminal state is P == 1,
// so the reload event coincides with the last prescaler period's tick.
// Assumes the preset is at least 2.
module prog_counter #(
    parameter int W = psdiv_pkg::P_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] preset,
    output logic         reload_evt
);
    logic [W-1:0] count;
    logic         at_one;

    // Terminal detect: every upper bit clear and the lowest bit set.
    assign at_one     = (count[W-1:1] == '0) && count[0];
    assign reload_evt = tick && at_one;

    // Reload from the preset at terminal, otherwise decrement per period.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= preset;
        else if (reload_evt) count <= preset;
        else if (tick)       count <= count - 1'b1;
    end
endmodule

// File: rtl/swallow_counter.sv
// Swallow counter S: it counts down once per prescaler period until it
// reaches zero, then holds at zero until the next reload. While it is
// non-zero it asks for the high prescaler modulus.
module swallow_counter #(
    parameter int W = psdiv_pkg::S_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] preset,
    output logic         active
);
    logic [W-1:0] count;

    assign active = (count != '0);

    // Load at reload; otherwise step down while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= preset;
        else if (load)           count <= preset;
        else if (tick && active) count <= count - 1'b1;
    end
endmodule

// File: rtl/pswallow_divider.sv
// Pulse-swallow programmable divider, ratio 4*P + S.
// Ties the prescaler, program counter and swallow counter together and
// registers the divided output and the reload pulse.
// Assumes legal presets: 2 <= P and S <= P.
module pswallow_divider #(
    parameter int P_W = psdiv_pkg::P_BITS,
    parameter int S_W = psdiv_pkg::S_BITS,
    parameter int N   = psdiv_pkg::PRE_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] p_preset,
    input  logic [S_W-1:0] s_preset,
    output logic           div_out,
    output logic           mode_ctl,
    output logic           reload
);
    logic ps_tick;
    logic reload_evt;
    logic div_q;
    logic reload_q;

    dm_prescaler #(.N(N)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_hi (mode_ctl),
        .tick   (ps_tick)
    );

    prog_counter #(.W(P_W)) u_pcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (ps_tick),
        .preset     (p_preset),
        .reload_evt (reload_evt)
    );

    swallow_counter #(.W(S_W)) u_scnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ps_tick),
        .load   (reload_evt),
        .preset (s_preset),
        .active (mode_ctl)
    );

    // Divided output: set at reload, cleared at the next prescaler period end.
    always_ff @(posedge clk) begin
        if (!rst_n)          div_q <= 1'b0;
        else if (reload_evt) div_q <= 1'b1;
        else if (ps_tick)    div_q <= 1'b0;
    end

    // Reload marker: a one-cycle registered copy of the reload event.
    always_ff @(posedge clk) begin
        if (!rst_n) reload_q <= 1'b0;
        else        reload_q <= reload_evt;
    end

    assign div_out = div_q;
    assign reload  = reload_q;
endmodule

// File: rtl/pswallow_divider_chk.sv
// Checker for the pulse-swallow divider, attached to the top by bind.
module pswallow_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic ps_tick,
    input logic reload_evt,
    input logic mode_ctl,
    input logic reload,
    input logic div_out
);
    // R4
    reload_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !reload);

    // R4
    reload_with_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> reload);

    // R3
    swallow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ctl && !reload_evt) |=> !mode_ctl);

    // R2
    mode_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_tick |=> $stable(mode_ctl));

    // R5
    div_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_out) |-> $past(ps_tick));
endmodule

bind pswallow_divider pswallow_divider_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ps_tick    (ps_tick),
    .reload_evt (reload_evt),
    .mode_ctl   (mode_ctl),
    .reload     (reload),
    .div_out    (div_out)
);

// File: tb/pswallow_divider_tb.sv
// Bench: applies legal preset pairs, a full sweep of ratios 240..400 and
// edge cases. It measures each output cycle at the ports.
module pswallow_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] p_preset = 7'd2;
    logic [1:0] s_preset = 2'd1;
    logic       div_out, mode_ctl, reload;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    int len = 0, mh = 0, rh = 0, dh = 0;
    int last_len = 0, last_mh = 0, last_rh = 0, last_dh = 0;
    int rise_cnt = 0;
    logic prev_div = 1'b0;

    int exp_p = 0, exp_s = 0;
    bit have_exp = 0;

    always #10 clk = ~clk;

    pswallow_divider u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .p_preset (p_preset),
        .s_preset (s_preset),
        .div_out  (div_out),
        .mode_ctl (mode_ctl),
        .reload   (reload)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (P=%0d S=%0d)", tag, act, exp, exp_p, exp_s);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    // Interval monitor: counts per output cycle, sampled at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_div = 1'b0;
        end else begin
            if (div_out && !prev_div) begin
                last_len = len; last_mh = mh; last_rh = rh; last_dh = dh;
                rise_cnt++;
                len = 1; mh = int'(mode_ctl); rh = int'(reload); dh = 1;
            end else begin
                len++;
                mh += int'(mode_ctl);
                rh += int'(reload);
                dh += int'(div_out);
            end
            prev_div = div_out;
        end
    end

    task automatic wait_rise();
        int n;
        n = rise_cnt;
        do @(posedge clk); while (rise_cnt == n);
        #1;
    endtask

    // Close one output cycle and check it against the presets loaded at its
    // start, then present the next preset pair (R6: it must only apply later).
    task automatic step(input int p, input int s);
        wait_rise();
        if (have_exp) begin
            check_eq("R1 ratio", last_len, 4 * exp_p + exp_s);
            check_eq("R2 divide-by-5 cycles", last_mh, 5 * exp_s);
            check_eq("R4 reload pulses", last_rh, 1);
            check_eq("R5 high time", last_dh, (exp_s > 0) ? 5 : 4);
            if (exp_p >= 60 && exp_p <= 100)
                check_eq("R8 sweep ratio", last_len, 4 * exp_p + exp_s);
        end
        exp_p = int'(p_preset);
        exp_s = int'(s_preset);
        have_exp = 1;
        p_preset = 7'(p);
        s_preset = 2'(s);
    endtask

    initial begin
        // R7: reset values, mode follows the swallow preset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R7 div_out in reset", int'(div_out), 0);
        check_eq("R7 reload in reset", int'(reload), 0);
        check_eq("R7 mode with S=1", int'(mode_ctl), 1);
        s_preset = 2'd0;
        @(posedge clk); @(negedge clk);
        check_eq("R7 mode with S=0", int'(mode_ctl), 0);
        s_preset = 2'd1;
        @(posedge clk); @(negedge clk);
        check_eq("R7 mode with S=1 again", int'(mode_ctl), 1);
        rst_n = 1'b1;

        // Each step changes presets mid-cycle; the next interval still uses
        // the earlier pair (R6).
        step(2, 0);
        step(2, 2);
        step(2, 1);
        step(3, 3);
        step(5, 3);
        step(127, 3);
        step(127, 0);
        step(112, 2);
        step(9, 1);
        // R8: every ratio 240..400.
        for (int m = 240; m <= 400; m++) step(m / 4, m % 4);
        step(112, 2);
        step(112, 2);
        step(112, 2);
        check_eq("R1 ratio 450", last_len, 450);
        summary();
        $finish;
    end
endmodule